// File: doc/BRIEF.md
# Configuration and Status Register Bank

This block gives a peripheral core a set of software-visible registers behind a plain synchronous slave bus. The bus presents an address on every cycle, may assert a write enable with write data, and receives read data one cycle later. Two kinds of register share one address space.

A pass-through register keeps no storage. A bus write to it is handed to the core as a data word with a one-cycle strobe. A bus read of it returns whatever the core is driving. A held register stores one field. That field can be wider than the bus word, in which case it spans consecutive addresses. The bus side and the core side each have their own access policy for the field: read-only, write-only or read-write. The core can load a new value into a core-writable field with a load enable, and it sees the stored value of a core-readable field at all times.

The number and width of pass-through registers, the number and width of held fields, and each field's policies and reset value are parameters. The default build has two 6-bit pass-through registers and three 12-bit fields. Field 0 is bus read-write and core read-only. Field 1 is bus read-only and core write-only. Field 2 is bus write-only and core read-write.

Top module: `csr_bank`

## Requirements
- R1: A bus write to pass-through register i raises `raw_stb[i]` for exactly the next cycle, with `raw_q` slot i holding the low RAW_W bits of the written word in that cycle; no write, no strobe.
- R2: A bus read of pass-through register i returns, one cycle later, the core's `raw_d` slot i value as sampled in the address cycle, zero-extended to the bus width.
- R3: The address map is fixed: pass-through register i sits at address i. Word j of field k sits at address NUM_RAW + k*WORDS + j, where WORDS = ceil(FLD_W/BUS_W). Word 0 holds the most significant chunk, and the unused high bits of that chunk read as zero.
- R4: A bus write to a word of a bus-writable field (policy bit 1 set) replaces only that chunk. The new value is visible from the next cycle.
- R5: A bus write to a field whose bus policy is read-only (2'b01) leaves the stored value unchanged.
- R6: A bus read of a field whose bus policy is write-only (2'b10) returns zero.
- R7: For a core-readable field (policy bit 0 set), `fld_q` slot k always shows the stored value. For a field that is not core-readable, it shows zero.
- R8: When `fld_ld[k]` is high and field k is core-writable, the field takes `fld_d` slot k at the next edge. `fld_ld` has no effect on a core read-only field.
- R9: If a core load and a bus write hit the same field in the same cycle, the core load wins for the whole field.
- R10: Read data is registered, with one cycle of latency. Unmapped addresses read as zero and ignore writes.
- R11: A synchronous active-high reset loads every field with its own RST_VAL slice, clears the read data and clears all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus word address |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | BUS_W | Bus write data |
| bus_rdata | output | BUS_W | Registered read data |
| raw_q | output | NUM_RAW*RAW_W | Last written word per pass-through register |
| raw_stb | output | NUM_RAW | One-cycle write strobe per pass-through register |
| raw_d | input | NUM_RAW*RAW_W | Core-driven read value per pass-through register |
| fld_q | output | NUM_FLD*FLD_W | Stored field values seen by the core |
| fld_d | input | NUM_FLD*FLD_W | Core load values |
| fld_ld | input | NUM_FLD | Core load enables |

## Verification
The embedded properties watch four things on every cycle:
- the one-cycle strobe timing and its captured data;
- that the decoded targets are mutually exclusive;
- zero read data after an unmapped address;
- field stability under an ignored bus write or core load, and the core load winning over a same-cycle bus write.

Other behaviours only come out through the bench scenarios, which compare against a behavioural model every clock. These are the chunk ordering of wide fields, zero-padding of the top chunk, the per-policy read gating, the pass-through read of live core values and the per-field reset values.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  // Access policy: bit 0 = may read, bit 1 = may write
  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_RO   = 2'b01,
    POL_WO   = 2'b10,
    POL_RW   = 2'b11
  } pol_e;

  function automatic int words_for(input int width, input int bus_w);
    return (width + bus_w - 1) / bus_w;
  endfunction

  function automatic int field_base(input int n_raw, input int idx, input int words);
    return n_raw + idx * words;
  endfunction

  function automatic bit may_read(input logic [1:0] pol);
    return pol[0];
  endfunction

  function automatic bit may_write(input logic [1:0] pol);
    return pol[1];
  endfunction

endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec #(
  parameter int ADDR_W  = 4,
  parameter int NUM_RAW = 2,
  parameter int NUM_FLD = 3,
  parameter int WORDS   = 2,
  parameter int WSEL_W  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_RAW-1:0] raw_hit,
  output logic [NUM_FLD-1:0] fld_hit,
  output logic [WSEL_W-1:0]  word_sel,
  output logic               mapped
);

  always_comb begin
    raw_hit  = '0;
    fld_hit  = '0;
    word_sel = '0;
    for (int i = 0; i < NUM_RAW; i++)
      if (int'(addr) == i) raw_hit[i] = 1'b1;
    for (int k = 0; k < NUM_FLD; k++)
      for (int j = 0; j < WORDS; j++)
        if (int'(addr) == csr_bank_pkg::field_base(NUM_RAW, k, WORDS) + j) begin
          fld_hit[k] = 1'b1;
          word_sel   = WSEL_W'(j);
        end
    mapped = (|raw_hit) | (|fld_hit);
  end

endmodule

// File: rtl/csr_raw_port.sv
module csr_raw_port #(
  parameter int BUS_W = 8,
  parameter int RAW_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [RAW_W-1:0] q,
  output logic             stb
);

  logic wr_ev;
  assign wr_ev = hit & bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb <= 1'b0;
      q   <= '0;
    end else begin
      stb <= wr_ev;
      if (wr_ev) q <= bus_wdata[RAW_W-1:0];
    end
  end

  // R1
  raw_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ev |=> (stb && q == $past(bus_wdata[RAW_W-1:0])));

  // R1
  raw_strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ev |=> !stb);

endmodule

// File: rtl/csr_field.sv
module csr_field #(
  parameter int          BUS_W    = 8,
  parameter int          FLD_W    = 12,
  parameter int          WORDS    = 2,
  parameter int          WSEL_W   = 1,
  parameter logic [1:0]  BUS_POL  = 2'b11,
  parameter logic [1:0]  CORE_POL = 2'b01,
  parameter logic [FLD_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_hit,
  input  logic              bus_we,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [FLD_W-1:0]  core_d,
  input  logic              core_ld,
  output logic [FLD_W-1:0]  core_q,
  output logic [BUS_W-1:0]  bus_word
);

  localparam int PAD_W = WORDS * BUS_W;

  logic [FLD_W-1:0] val;
  logic [PAD_W-1:0] val_pad, merged;
  logic             bus_wr_ev, core_wr_ev, bus_try;

  assign val_pad    = PAD_W'(val);
  assign bus_try    = bus_hit & bus_we;
  assign bus_wr_ev  = bus_try & csr_bank_pkg::may_write(BUS_POL);
  assign core_wr_ev = core_ld & csr_bank_pkg::may_write(CORE_POL);

  always_comb begin
    merged   = val_pad;
    bus_word = '0;
    for (int j = 0; j < WORDS; j++)
      if (int'(word_sel) == j) begin
        merged[(WORDS-1-j)*BUS_W +: BUS_W] = bus_wdata;
        bus_word = val_pad[(WORDS-1-j)*BUS_W +: BUS_W];
      end
    if (!csr_bank_pkg::may_read(BUS_POL)) bus_word = '0;
  end

  assign core_q = csr_bank_pkg::may_read(CORE_POL) ? val : '0;

  always_ff @(posedge clk) begin
    if (rst)             val <= RST_VAL;
    else if (core_wr_ev) val <= core_d;
    else if (bus_wr_ev)  val <= merged[FLD_W-1:0];
  end

  // R9
  core_wins_chk: assert property (@(posedge clk) disable iff (rst)
    core_wr_ev |=> val == $past(core_d));

  // R5
  bus_ro_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_try && !bus_wr_ev && !core_wr_ev) |=> $stable(val));

  // R8
  core_ro_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (core_ld && !core_wr_ev && !bus_wr_ev) |=> $stable(val));

endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
  parameter int ADDR_W  = 4,
  parameter int BUS_W   = 8,
  parameter int NUM_RAW = 2,
  parameter int RAW_W   = 6,
  parameter int NUM_FLD = 3,
  parameter int FLD_W   = 12,
  parameter logic [2*NUM_FLD-1:0]     BUS_POL  = 6'b10_01_11,
  parameter logic [2*NUM_FLD-1:0]     CORE_POL = 6'b11_10_01,
  parameter logic [NUM_FLD*FLD_W-1:0] RST_VAL  = 36'h0C7_3F1_A5C
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [BUS_W-1:0]         bus_wdata,
  output logic [BUS_W-1:0]         bus_rdata,
  output logic [NUM_RAW*RAW_W-1:0] raw_q,
  output logic [NUM_RAW-1:0]       raw_stb,
  input  logic [NUM_RAW*RAW_W-1:0] raw_d,
  output logic [NUM_FLD*FLD_W-1:0] fld_q,
  input  logic [NUM_FLD*FLD_W-1:0] fld_d,
  input  logic [NUM_FLD-1:0]       fld_ld
);

  localparam int WORDS  = csr_bank_pkg::words_for(FLD_W, BUS_W);
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [NUM_RAW-1:0] raw_hit;
  logic [NUM_FLD-1:0] fld_hit;
  logic [WSEL_W-1:0]  word_sel;
  logic               dec_mapped;
  logic [BUS_W-1:0]   fld_word [NUM_FLD];
  logic [BUS_W-1:0]   rd_next;

  initial raw_width_chk: assert (RAW_W <= BUS_W);

  csr_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_RAW(NUM_RAW), .NUM_FLD(NUM_FLD),
    .WORDS(WORDS), .WSEL_W(WSEL_W)
  ) u_dec (
    .addr(bus_addr), .raw_hit(raw_hit), .fld_hit(fld_hit),
    .word_sel(word_sel), .mapped(dec_mapped)
  );

  for (genvar i = 0; i < NUM_RAW; i++) begin : g_raw
    csr_raw_port #(.BUS_W(BUS_W), .RAW_W(RAW_W)) u_raw (
      .clk(clk), .rst(rst), .hit(raw_hit[i]), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .q(raw_q[i*RAW_W +: RAW_W]), .stb(raw_stb[i])
    );
  end

  for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
    csr_field #(
      .BUS_W(BUS_W), .FLD_W(FLD_W), .WORDS(WORDS), .WSEL_W(WSEL_W),
      .BUS_POL(BUS_POL[2*k +: 2]), .CORE_POL(CORE_POL[2*k +: 2]),
      .RST_VAL(RST_VAL[k*FLD_W +: FLD_W])
    ) u_fld (
      .clk(clk), .rst(rst), .bus_hit(fld_hit[k]), .bus_we(bus_we),
      .word_sel(word_sel), .bus_wdata(bus_wdata),
      .core_d(fld_d[k*FLD_W +: FLD_W]), .core_ld(fld_ld[k]),
      .core_q(fld_q[k*FLD_W +: FLD_W]), .bus_word(fld_word[k])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_RAW; i++)
      if (raw_hit[i]) rd_next = BUS_W'(raw_d[i*RAW_W +: RAW_W]);
    for (int k = 0; k < NUM_FLD; k++)
      if (fld_hit[k]) rd_next = fld_word[k];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R3
  dec_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({raw_hit, fld_hit}));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_mapped |=> bus_rdata == '0);

endmodule

// File: tb/csr_bank_test.sv
module csr_bank_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  addr;
  logic        we;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [11:0] raw_q;
  logic [1:0]  raw_stb;
  logic [11:0] raw_d;
  logic [35:0] fld_q;
  logic [35:0] fld_d;
  logic [2:0]  fld_ld;

  int checks = 0;
  int errors = 0;
  int fv [3];
  int rstv  [3] = '{'hA5C, 'h3F1, 'h0C7};
  int pbus  [3] = '{3, 1, 2};
  int pcore [3] = '{1, 2, 3};

  always #2 clk = ~clk;

  csr_bank uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .raw_q(raw_q), .raw_stb(raw_stb), .raw_d(raw_d),
    .fld_q(fld_q), .fld_d(fld_d), .fld_ld(fld_ld)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    int a, k, j, e_rd;
    int e_stb [2];
    int e_q   [2];
    a = int'(addr);
    e_rd = 0;
    e_stb = '{0, 0};
    e_q = '{0, 0};
    if (a < 2) e_rd = (raw_d >> (6 * a)) & 'h3F;
    else if (a < 8) begin
      k = (a - 2) / 2;
      j = (a - 2) % 2;
      if (pbus[k] & 1) e_rd = (j == 0) ? (fv[k] >> 8) & 'hF : fv[k] & 'hFF;
    end
    if (we && a < 2) begin
      e_stb[a] = 1;
      e_q[a] = wdata & 'h3F;
    end
    for (int f = 0; f < 3; f++) begin
      if ((pcore[f] & 2) && fld_ld[f]) fv[f] = int'((fld_d >> (12 * f)) & 36'hFFF);
      else if (we && a >= 2 && a < 8 && (a - 2) / 2 == f && (pbus[f] & 2)) begin
        if ((a - 2) % 2 == 0) fv[f] = (fv[f] & 'h0FF) | ((wdata & 'hF) << 8);
        else                  fv[f] = (fv[f] & 'hF00) | wdata;
      end
    end
    if (rst) begin
      fv = rstv;
      e_rd = 0;
      e_stb = '{0, 0};
    end
    @(posedge clk);
    #1;
    chk(tag, "rdata", int'(rdata), e_rd);
    for (int i = 0; i < 2; i++) begin
      chk(tag, "raw_stb", int'(raw_stb[i]), e_stb[i]);
      if (e_stb[i] != 0) chk(tag, "raw_q", int'((raw_q >> (6 * i)) & 12'h3F), e_q[i]);
    end
    for (int f = 0; f < 3; f++)
      chk(tag, "fld_q", int'((fld_q >> (12 * f)) & 36'hFFF), (pcore[f] & 1) ? fv[f] : 0);
  endtask

  task automatic bus(input string tag, input int a, input bit w, input int d);
    addr = 4'(a);
    we = w;
    wdata = 8'(d);
    step(tag);
    we = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; addr = '0; we = 1'b0; wdata = '0;
    raw_d = 12'h9A5; fld_d = '0; fld_ld = '0;
    fv = rstv;
    step("R11");
    step("R11");
    rst = 1'b0;
    // reset values, map, bus WO reads zero, unmapped zero
    for (int a = 0; a < 16; a++) bus("R3", a, 1'b0, 0);
    bus("R6", 6, 1'b0, 0);
    bus("R10", 12, 1'b0, 0);
    // pass-through registers
    bus("R1", 0, 1'b1, 'hFF);
    bus("R1", 1, 1'b1, 'h5A);
    bus("R1", 1, 1'b0, 0);
    raw_d = 12'h3C1;
    bus("R2", 0, 1'b0, 0);
    raw_d = 12'h0BE;
    bus("R2", 1, 1'b0, 0);
    // bus writes to field 0 (RW/RO)
    bus("R4", 2, 1'b1, 'hF7);
    bus("R4", 3, 1'b1, 'h19);
    bus("R4", 2, 1'b0, 0);
    bus("R4", 3, 1'b0, 0);
    // field 1 bus read-only
    bus("R5", 4, 1'b1, 'h00);
    bus("R5", 5, 1'b1, 'h00);
    bus("R5", 5, 1'b0, 0);
    bus("R5", 4, 1'b0, 0);
    // field 2 bus write-only, core readable
    bus("R6", 7, 1'b1, 'h88);
    bus("R6", 6, 1'b1, 'h0D);
    bus("R7", 7, 1'b0, 0);
    // core loads
    fld_d = {12'h111, 12'hBCD, 12'h777};
    fld_ld = 3'b011;
    bus("R8", 4, 1'b0, 0);
    fld_ld = '0;
    bus("R8", 4, 1'b0, 0);
    bus("R8", 5, 1'b0, 0);
    bus("R8", 3, 1'b0, 0);
    // same-cycle core load and bus write on field 2
    fld_d = {12'h6E2, 12'h000, 12'h000};
    fld_ld = 3'b100;
    bus("R9", 7, 1'b1, 'h33);
    fld_ld = '0;
    bus("R9", 7, 1'b1, 'h44);
    bus("R9", 0, 1'b0, 0);
    // unmapped writes ignored
    bus("R10", 9, 1'b1, 'hAB);
    bus("R10", 15, 1'b1, 'hCD);
    for (int a = 0; a < 10; a++) bus("R10", a, 1'b0, 0);
    // reset mid-run
    addr = 4'd2; rst = 1'b1;
    step("R11");
    rst = 1'b0;
    bus("R11", 2, 1'b0, 0);
    bus("R11", 3, 1'b0, 0);
    bus("R11", 5, 1'b0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule